// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Controller

This block sits between a CPU's 24-bit address bus and the external memory devices. It compares each bus address against four programmable address windows, called areas 0 to 3. For the winning area it drives one active-low chip-select pin, reports whether the external data bus is 8 or 16 bits wide, and holds the bus ready line low for the programmed number of wait cycles after the address strobe.

Addresses that hit no enabled area fall through to a fallback control register, which is always in force. Addresses inside the on-chip I/O and RAM windows never produce a chip select. Area 2 is special. Out of reset it covers a large fixed region with two holes. Setting its mode bit makes it decode from its own start and mask registers, in the same way as the other areas.

Software loads the configuration through a byte-wide register write port. The usual order is the start registers, then the masks, then the control registers.

Top module: `bus_area_decoder`

## Requirements
- R1: After reset every chip-select pin is high, ready is low, and every register reads as zero. In particular the area 2 mode bit is 0 and the pin-enable register is 0.
- R2: An enabled area matches when `((A[23:16] ^ start) & care) == 0`, where `care[j]` is cleared by mask bit `j+3` for j = 0..4, and `care[7:5]` is always 1. Mask bits 2:0 have no effect. Start 01H with mask 07H gives exactly 010000H–01FFFFH.
- R3: With area 2 mode bit (control bit 6) at 0, area 2 covers 000FE0H–000FFFH and 003000H–FFFFFFH. With the bit at 1, area 2 decodes by R2 from its own start and mask registers.
- R4: An address in 000000H–000FDFH or 001000H–002FFFH asserts no chip select, whatever the areas hold. Such an access reports a 16-bit width and zero waits.
- R5: When several areas match, area 0 wins over 1, 1 over 2, and 2 over 3. At most one chip-select pin is low. An area whose enable bit is 0 never matches.
- R6: An external address that matches no area asserts no chip select. It takes its width and wait count from the fallback register.
- R7: Chip-select pin i goes low only when area i wins and bit i of the pin-enable register is 1. Otherwise the pin stays high.
- R8: Control byte layout: bit 7 is the enable, bit 1 is the width (1 = 16-bit), and bits 5:4 are the wait count. A value of 83H means enabled, 16-bit, zero waits.
- R9: A strobe accepted while idle latches the selected wait count N. Ready then stays low for N cycles, is high for exactly one cycle, and then returns low. A strobe that arrives while an access is in progress is ignored.
- R10: The register indices are: 0–3 start, 4–7 mask, 8–11 control, 12 fallback control, 13 pin enable. Writes to indices 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write data |
| bus_addr | input | 24 | CPU bus address, held for the whole access |
| bus_strobe | input | 1 | Address strobe, starts an access |
| cs_n | output | 4 | Active-low chip selects, one per area |
| bus_wide | output | 1 | Selected data bus width (1 = 16-bit) |
| bus_ready | output | 1 | One-cycle ready pulse that ends an access |

## Verification
A wrong comparator, priority or suppression term shows up on `cs_n` and `bus_wide` in the same cycle as the address, so every swept address exposes it at once. A wrong wait counter or busy flag shows up as a ready pulse one or more cycles early or late, or as a missing or doubled pulse, within N+2 cycles of the strobe. A register written to the wrong index shows up only on the addresses that index governs, so the sweeps cover every 64-Kbyte page under two area layouts.

// File: rtl/bus_area_pkg.sv
package bus_area_pkg;

   typedef struct packed {
      logic       en;
      logic       fixed_off;
      logic [1:0] waits;
      logic       wide;
   } area_ctrl_t;

   localparam int unsigned CTRL_EN_BIT    = 7;
   localparam int unsigned CTRL_MODE_BIT  = 6;
   localparam int unsigned CTRL_WAIT_LSB  = 4;
   localparam int unsigned CTRL_WIDE_BIT  = 1;
   localparam int unsigned MASK_SKIP_BITS = 3;

   function automatic area_ctrl_t unpack_ctrl(input logic [7:0] b);
      area_ctrl_t c;
      c.en        = b[CTRL_EN_BIT];
      c.fixed_off = b[CTRL_MODE_BIT];
      c.waits     = b[CTRL_WAIT_LSB +: 2];
      c.wide      = b[CTRL_WIDE_BIT];
      return c;
   endfunction

endpackage

// File: rtl/area_cfg_bank.sv
module area_cfg_bank #(
   parameter int unsigned N_AREAS = 4,
   parameter int unsigned SEL_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [SEL_W-1:0]          sel,
   input  logic [7:0]                wdata,
   output logic [N_AREAS-1:0][7:0]   start_q,
   output logic [N_AREAS-1:0][7:0]   mask_q,
   output logic [N_AREAS-1:0][7:0]   ctrl_q,
   output logic [7:0]                fb_q,
   output logic [N_AREAS-1:0]        pin_en_q
);
   localparam int unsigned MASK_BASE = N_AREAS;
   localparam int unsigned CTRL_BASE = 2 * N_AREAS;
   localparam int unsigned FB_IDX    = 3 * N_AREAS;
   localparam int unsigned PIN_IDX   = 3 * N_AREAS + 1;

   for (genvar i = 0; i < N_AREAS; i++) begin : g_area_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_q[i] <= '0;
            mask_q[i]  <= '0;
            ctrl_q[i]  <= '0;
         end else if (we) begin
            if (32'(sel) == i)             start_q[i] <= wdata;
            if (32'(sel) == MASK_BASE + i) mask_q[i]  <= wdata;
            if (32'(sel) == CTRL_BASE + i) ctrl_q[i]  <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_q     <= '0;
         pin_en_q <= '0;
      end else if (we) begin
         if (32'(sel) == FB_IDX)  fb_q     <= wdata;
         if (32'(sel) == PIN_IDX) pin_en_q <= wdata[N_AREAS-1:0];
      end
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata;
endmodule

// File: rtl/area_window_match.sv
module area_window_match
   import bus_area_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter bit          HAS_FIXED   = 1'b0,
   parameter logic [ADDR_W-1:0] FIX_A_LO = 24'h000FE0,
   parameter logic [ADDR_W-1:0] FIX_A_HI = 24'h000FFF,
   parameter logic [ADDR_W-1:0] FIX_B_LO = 24'h003000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        start,
   input  logic [7:0]        mask,
   input  area_ctrl_t        ctrl,
   output logic              hit
);
   localparam int unsigned PAGE_LSB = ADDR_W - 8;
   localparam int unsigned CARE_N   = 8 - MASK_SKIP_BITS;

   logic [7:0] care;
   logic       win_hit;

   for (genvar j = 0; j < 8; j++) begin : g_care
      if (j < CARE_N) begin : g_maskable
         assign care[j] = ~mask[j + MASK_SKIP_BITS];
      end else begin : g_fixed
         assign care[j] = 1'b1;
      end
   end

   assign win_hit = (((addr[ADDR_W-1:PAGE_LSB] ^ start) & care) == 8'h00);

   if (HAS_FIXED) begin : g_fixed_mode
      logic fix_hit;
      assign fix_hit = ((addr >= FIX_A_LO) && (addr <= FIX_A_HI)) ||
                       (addr >= FIX_B_LO);
      assign hit = ctrl.en && (ctrl.fixed_off ? win_hit : fix_hit);
   end else begin : g_window_only
      logic unused_mode;
      assign unused_mode = ctrl.fixed_off;
      assign hit = ctrl.en && win_hit;
   end

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl.waits, ctrl.wide, mask[MASK_SKIP_BITS-1:0]};
endmodule

// File: rtl/area_arbiter.sv
module area_arbiter
   import bus_area_pkg::*;
#(
   parameter int unsigned N_AREAS = 4
) (
   input  logic [N_AREAS-1:0]       hit,
   input  area_ctrl_t [N_AREAS-1:0] ctrl,
   input  area_ctrl_t               fb,
   input  logic                     internal,
   input  logic [N_AREAS-1:0]       pin_en,
   output logic [N_AREAS-1:0]       cs_n,
   output logic                     wide,
   output logic [1:0]               waits
);
   logic [N_AREAS-1:0] grant;
   logic [N_AREAS-1:0] lower_taken;

   for (genvar i = 0; i < N_AREAS; i++) begin : g_prio
      if (i == 0) begin : g_top
         assign lower_taken[i] = 1'b0;
      end else begin : g_rest
         assign lower_taken[i] = lower_taken[i-1] | hit[i-1];
      end
      assign grant[i] = hit[i] & ~lower_taken[i] & ~internal;
      assign cs_n[i]  = ~(grant[i] & pin_en[i]);
   end

   always_comb begin
      wide  = fb.wide;
      waits = fb.waits;
      if (internal) begin
         wide  = 1'b1;
         waits = 2'd0;
      end else begin
         for (int k = N_AREAS - 1; k >= 0; k--) begin
            if (grant[k]) begin
               wide  = ctrl[k].wide;
               waits = ctrl[k].waits;
            end
         end
      end
   end

   logic unused_fb;
   assign unused_fb = fb.en ^ fb.fixed_off;
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
   parameter int unsigned WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [WAIT_W-1:0] waits,
   output logic              busy,
   output logic              ready
);
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (!busy) begin
         if (strobe) begin
            busy  <= 1'b1;
            cnt_q <= waits;
         end
      end else if (cnt_q == '0) begin
         busy <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = busy && (cnt_q == '0);
endmodule

// File: rtl/bus_area_decoder.sv
module bus_area_decoder
   import bus_area_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned N_AREAS    = 4,
   parameter int unsigned FIXED_AREA = 2,
   parameter logic [ADDR_W-1:0] IO_HI    = 24'h000FDF,
   parameter logic [ADDR_W-1:0] RAM_LO   = 24'h001000,
   parameter logic [ADDR_W-1:0] RAM_HI   = 24'h002FFF,
   parameter logic [ADDR_W-1:0] FIX_A_LO = 24'h000FE0,
   parameter logic [ADDR_W-1:0] FIX_A_HI = 24'h000FFF,
   parameter logic [ADDR_W-1:0] FIX_B_LO = 24'h003000,
   localparam int unsigned SEL_W = $clog2(3 * N_AREAS + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [7:0]         cfg_wdata,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_strobe,
   output logic [N_AREAS-1:0] cs_n,
   output logic               bus_wide,
   output logic               bus_ready
);
   if (ADDR_W < 17) begin : g_bad_addr_w
      $error("bus_area_decoder: ADDR_W must be at least 17");
   end
   if (FIXED_AREA >= N_AREAS) begin : g_bad_fixed
      $error("bus_area_decoder: FIXED_AREA out of range");
   end
   if (N_AREAS > 8) begin : g_bad_n
      $error("bus_area_decoder: pin-enable register holds at most 8 areas");
   end

   logic [N_AREAS-1:0][7:0] start_q, mask_q, ctrl_raw;
   logic [7:0]              fb_raw;
   logic [N_AREAS-1:0]      pin_en;
   area_ctrl_t [N_AREAS-1:0] ctrl;
   area_ctrl_t              fb;
   logic [N_AREAS-1:0]      hit;
   logic                    int_hit;
   logic [1:0]              sel_waits;
   logic                    tmr_busy;

   area_cfg_bank #(.N_AREAS(N_AREAS), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .start_q(start_q), .mask_q(mask_q), .ctrl_q(ctrl_raw),
      .fb_q(fb_raw), .pin_en_q(pin_en)
   );

   assign fb = unpack_ctrl(fb_raw);

   for (genvar i = 0; i < N_AREAS; i++) begin : g_area
      assign ctrl[i] = unpack_ctrl(ctrl_raw[i]);
      area_window_match #(
         .ADDR_W(ADDR_W), .HAS_FIXED(i == FIXED_AREA),
         .FIX_A_LO(FIX_A_LO), .FIX_A_HI(FIX_A_HI), .FIX_B_LO(FIX_B_LO)
      ) u_match (
         .addr(bus_addr), .start(start_q[i]), .mask(mask_q[i]),
         .ctrl(ctrl[i]), .hit(hit[i])
      );
   end

   assign int_hit = (bus_addr <= IO_HI) ||
                    ((bus_addr >= RAM_LO) && (bus_addr <= RAM_HI));

   area_arbiter #(.N_AREAS(N_AREAS)) u_arb (
      .hit(hit), .ctrl(ctrl), .fb(fb), .internal(int_hit), .pin_en(pin_en),
      .cs_n(cs_n), .wide(bus_wide), .waits(sel_waits)
   );

   wait_timer #(.WAIT_W(2)) u_timer (
      .clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .waits(sel_waits),
      .busy(tmr_busy), .ready(bus_ready)
   );
endmodule

// File: rtl/bus_area_decoder_chk.sv
module bus_area_decoder_chk #(
   parameter int unsigned N_AREAS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_AREAS-1:0] cs_n,
   input logic [N_AREAS-1:0] pin_en,
   input logic               int_hit,
   input logic               bus_strobe,
   input logic               tmr_busy,
   input logic [1:0]         sel_waits,
   input logic               bus_ready
);
   // R5
   one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R4
   internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_hit |-> (&cs_n));
   // R7
   pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cs_n) & ~pin_en) == '0);
   // R9
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);
   // R9
   zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && !tmr_busy && sel_waits == 2'd0) |=> bus_ready);
   // R9
   held_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && !tmr_busy && sel_waits != 2'd0) |=> !bus_ready);
   // R9
   ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> tmr_busy);
endmodule

bind bus_area_decoder bus_area_decoder_chk #(.N_AREAS(N_AREAS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pin_en(pin_en), .int_hit(int_hit),
   .bus_strobe(bus_strobe), .tmr_busy(tmr_busy), .sel_waits(sel_waits),
   .bus_ready(bus_ready)
);

// File: tb/bus_area_decoder_test.sv
module bus_area_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [23:0] bus_addr = '0;
   logic        bus_strobe = 1'b0;
   logic [3:0]  cs_n;
   logic        bus_wide;
   logic        bus_ready;

   int checks = 0;
   int failures = 0;

   logic [7:0] s_start [4];
   logic [7:0] s_mask  [4];
   logic [7:0] s_ctrl  [4];
   logic [7:0] s_fb;
   logic [7:0] s_pin;

   always #10 clk = ~clk;

   bus_area_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
      .cs_n(cs_n), .bus_wide(bus_wide), .bus_ready(bus_ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected {cs_n, wide, waits} from R2..R8
   function automatic logic [6:0] model(input logic [23:0] a);
      logic [7:0] care;
      logic hit;
      if (a <= 24'h000FDF || (a >= 24'h001000 && a <= 24'h002FFF))
         return {4'hF, 1'b1, 2'd0};
      for (int i = 0; i < 4; i++) begin
         care = ~{3'b000, s_mask[i][7:3]};
         if (i == 2 && !s_ctrl[2][6])
            hit = (a >= 24'h000FE0 && a <= 24'h000FFF) || (a >= 24'h003000);
         else
            hit = (((a[23:16] ^ s_start[i]) & care) == 8'h00);
         if (s_ctrl[i][7] && hit)
            return {(s_pin[i] ? ~(4'b0001 << i) : 4'hF), s_ctrl[i][1], s_ctrl[i][5:4]};
      end
      return {4'hF, s_fb[1], s_fb[5:4]};
   endfunction

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 4) s_start[idx] = d;
      else if (idx < 8) s_mask[idx-4] = d;
      else if (idx < 12) s_ctrl[idx-8] = d;
      else if (idx == 12) s_fb = d;
      else if (idx == 13) s_pin = d;
   endtask

   // Decode check plus full ready sequence (R9)
   task automatic access(input logic [23:0] a, input string req);
      logic [6:0] e;
      e = model(a);
      @(negedge clk);
      bus_addr = a; bus_strobe = 1'b1;
      #2;
      check(cs_n == e[6:3], req, cs_n, e[6:3]);
      check(bus_wide == e[2], req, bus_wide, e[2]);
      @(negedge clk);
      bus_strobe = 1'b0;
      for (int k = 0; k < int'(e[1:0]); k++) begin
         check(bus_ready == 1'b0, "R9 wait low", bus_ready, 0);
         @(negedge clk);
      end
      check(bus_ready == 1'b1, "R9 ready pulse", bus_ready, 1);
      @(negedge clk);
      check(bus_ready == 1'b0, "R9 ready ends", bus_ready, 0);
   endtask

   task automatic sweep(input string req);
      for (int p = 0; p < 256; p++) access({8'(p), 16'h8000}, req);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         s_start[i] = '0; s_mask[i] = '0; s_ctrl[i] = '0;
      end
      s_fb = '0; s_pin = '0;
      #35;
      // R1 reset state
      check(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
      check(bus_ready == 1'b0, "R1 ready", bus_ready, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check(cs_n == 4'hF && bus_ready == 1'b0, "R1 after release", cs_n, 4'hF);

      // R1/R3: enable area 2 only, mode bit untouched -> fixed region
      wr(13, 8'h0F);
      wr(10, 8'h80);
      access(24'h003000, "R3 fixed low edge");
      access(24'h000FE0, "R3 fixed hole lo");
      access(24'h000FFF, "R3 fixed hole hi");
      access(24'hFFFFFF, "R3 fixed top");
      access(24'h000FDF, "R4 io top");
      access(24'h001000, "R4 ram low");
      access(24'h002FFF, "R4 ram top");
      access(24'h000000, "R4 zero");

      // Layout A (R2, R5, R8): overlapping areas
      wr(0, 8'h01); wr(4, 8'h07); wr(8, 8'h83);
      wr(1, 8'h00); wr(5, 8'h0F); wr(9, 8'h91);
      wr(3, 8'h80); wr(7, 8'hFF); wr(11, 8'hB2);
      wr(10, 8'hA2);
      wr(12, 8'h12);
      sweep("R2 R5 R8 layout A");
      access(24'h010000, "R2 window low");
      access(24'h01FFFF, "R2 window high");
      access(24'h020000, "R2 outside");

      // Layout B: area 2 windowed, pin 2 off, area 1 disabled, fallback used
      wr(2, 8'h40); wr(6, 8'h0F); wr(10, 8'hC2);
      wr(9, 8'h11);
      wr(13, 8'h0B);
      wr(12, 8'h32);
      sweep("R3 R6 R7 layout B");
      access(24'h410000, "R7 pin off area 2");
      access(24'h600000, "R6 fallback");

      // R10: indices 14 and 15 change nothing
      wr(14, 8'hFF);
      wr(15, 8'h00);
      access(24'h010000, "R10 ignored idx area0");
      access(24'h600000, "R10 ignored idx fallback");
      access(24'h850000, "R10 ignored idx area3");

      // R9: strobe during access ignored
      @(negedge clk);
      bus_addr = 24'h850000; bus_strobe = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check(bus_ready == 1'b0, "R9 busy strobe", bus_ready, 0);
         @(negedge clk);
      end
      check(bus_ready == 1'b1, "R9 busy strobe pulse", bus_ready, 1);
      bus_strobe = 1'b0;
      @(negedge clk);
      check(bus_ready == 1'b0, "R9 busy strobe end", bus_ready, 0);
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule